// File: doc/BRIEF.md
# SDRAM Burst Data Path with Byte Masking

This block is the device-side data path of a single-data-rate SDRAM, reduced to one open page. Each clock it takes a decoded column command (no-op, read, write or burst stop) with a column address. It walks the programmed burst through the page and returns read words on a 16-bit bus after the programmed CAS latency. Write words are taken from the input bus on the same clocks as the burst addresses they belong to. Each byte lane has its own output-enable flag that stands in for the pad's high-impedance control.

Two byte-mask inputs gate the lanes. Their timing depends on direction: a mask bit blocks the lane of a write on the same clock, but it silences a read lane two clocks after it is sampled. A new read or write may be issued on any clock. It throws away what is left of the running burst and starts a full burst at its own column. A burst stop ends the burst where it stands. A mode input limits writes to a single word while reads keep the programmed burst length. The page is a small register array that is cleared by reset.

Top module: `sdr_burst_datapath`

## Requirements
- R1: Command encoding on `cmd`: 0 = no-op, 1 = read, 2 = write, 3 = burst stop. The first word of a read registered at edge T appears on `rd_data` with `rd_oe` = 2'b11 in the cycle after edge T+L. L is 2 when `cfg_cl3` = 0 and 3 when `cfg_cl3` = 1.
- R2: `cfg_blen` codes 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 words. The words of a burst come out on consecutive cycles, and `rd_oe` returns to 0 in the cycle after the last one.
- R3: Word i of a burst of length N that starts at column S uses column (S - S mod N) + ((S mod N + i) mod N) when `cfg_interleave` = 0, and (S - S mod N) + ((S mod N) XOR i) when `cfg_interleave` = 1.
- R4: During reads, `dqm[b]` sampled high at edge T makes `rd_oe[b]` low and byte b of `rd_data` zero in the cycle after edge T+2, for either CAS latency. Lane 0 is bits 7:0 and lane 1 is bits 15:8.
- R5: A write stores `wdata` at the start column on the clock it is registered, and stores the following words on the following clocks. A byte lane whose `dqm` bit is high on a given clock keeps its old contents for that word.
- R6: A read or write registered while a burst runs discards the rest of that burst and starts a full-length burst at its own column. Commands may follow one another on every clock, and read words already scheduled are still delivered.
- R7: A burst stop during a write burst keeps every word registered before it. `wdata` presented on the stop clock and after it changes nothing.
- R8: A burst stop at edge T during a read burst lets only the words issued before T come out, and `rd_oe` is 0 from the cycle after edge T+L onward.
- R9: With `cfg_single_wr` = 1, a write stores exactly one word at its column, while reads still return the programmed burst length.
- R10: After reset `rd_oe` is 0, `rd_data` is 0 and every page word reads back as 0. In any cycle where a lane's `rd_oe` bit is 0, that byte of `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 2 | Decoded column command |
| col | input | COL_W (4) | Column address of a read or write |
| dqm | input | DATA_W/8 (2) | Per-byte mask, lane 0 low byte |
| wdata | input | DATA_W (16) | Write data |
| cfg_cl3 | input | 1 | CAS latency select: 0 = 2 clocks, 1 = 3 clocks |
| cfg_blen | input | 2 | Burst length code |
| cfg_interleave | input | 1 | Burst order: 0 sequential, 1 interleaved |
| cfg_single_wr | input | 1 | Single-word write mode |
| rd_data | output | DATA_W (16) | Read data, zero on disabled lanes |
| rd_oe | output | DATA_W/8 (2) | Per-lane output enable |

## Verification
The latency and stop-drain properties assume that the mode inputs (`cfg_cl3`, `cfg_blen`, `cfg_interleave`, `cfg_single_wr`) stay constant from a command until its last read word has left the pipeline, as a mode register would. The stimulus honours this: it changes the configuration only between tests, after enough idle clocks for the read pipeline to drain. The properties also assume that the command code is one of the four legal encodings on every clock, which holds by the width of `cmd`. Read-mask pulses are timed against the issue clock of the word they are meant to hit, so each masked lane can be checked on its own cycle.

// File: rtl/sdr_dp_pkg.sv
package sdr_dp_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_STOP  = 2'd3
    } sdr_cmd_e;

    // deepest CAS latency supported by the read pipeline
    localparam int MAX_CL      = 3;
    // shortest CAS latency; selects the earlier pipeline tap
    localparam int MIN_CL      = 2;
    // clocks between a read mask sample and the silenced lane
    localparam int RD_MASK_LAT = 2;
    // burst offset width (longest burst is 8 words)
    localparam int OFF_W       = 3;

    // wrap mask of a burst: length minus one
    function automatic logic [OFF_W-1:0] len_mask(input logic [1:0] code);
        logic [3:0] span;
        span = (4'd1 << code) - 4'd1;
        return span[OFF_W-1:0];
    endfunction

endpackage

// File: rtl/sdr_col_gen.sv
module sdr_col_gen
    import sdr_dp_pkg::*;
#(
    parameter int COL_W = 4
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [OFF_W-1:0] idx,
    input  logic [OFF_W-1:0] wrap_mask,
    input  logic             interleave,
    output logic [COL_W-1:0] col
);

    logic [OFF_W-1:0] low;
    logic [OFF_W-1:0] step;

    always_comb begin
        low  = start_col[OFF_W-1:0];
        step = interleave ? (low ^ idx) : (low + idx);
        col  = start_col;
        // bits above the wrap mask stay on the start block
        col[OFF_W-1:0] = (low & ~wrap_mask) | (step & wrap_mask);
    end

endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
    import sdr_dp_pkg::*;
#(
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sdr_cmd_e         cmd,
    input  logic [COL_W-1:0] col,
    input  logic [1:0]       blen_code,
    input  logic             interleave,
    input  logic             single_wr,
    output logic             iss_valid,
    output logic             iss_write,
    output logic [COL_W-1:0] iss_col
);

    typedef struct packed {
        logic             active;
        logic             is_write;
        logic             il;
        logic [COL_W-1:0] start;
        logic [OFF_W-1:0] idx;
        logic [OFF_W-1:0] last;
        logic [OFF_W-1:0] wrap;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [COL_W-1:0] gen_start;
    logic [OFF_W-1:0] gen_idx;
    logic [OFF_W-1:0] gen_wrap;
    logic             gen_il;
    logic [OFF_W-1:0] new_wrap;
    logic [OFF_W-1:0] new_last;

    always_comb begin
        seq_d     = seq_q;
        iss_valid = 1'b0;
        iss_write = seq_q.is_write;
        gen_start = seq_q.start;
        gen_idx   = seq_q.idx;
        gen_wrap  = seq_q.wrap;
        gen_il    = seq_q.il;
        new_wrap  = len_mask(blen_code);
        new_last  = (cmd == CMD_WRITE && single_wr) ? '0 : new_wrap;

        case (cmd)
            CMD_READ, CMD_WRITE: begin
                // a new column command restarts a full burst here
                iss_valid      = 1'b1;
                iss_write      = (cmd == CMD_WRITE);
                gen_start      = col;
                gen_idx        = '0;
                gen_wrap       = new_wrap;
                gen_il         = interleave;
                seq_d.active   = (new_last != '0);
                seq_d.is_write = (cmd == CMD_WRITE);
                seq_d.il       = interleave;
                seq_d.start    = col;
                seq_d.idx      = OFF_W'(1);
                seq_d.last     = new_last;
                seq_d.wrap     = new_wrap;
            end
            CMD_STOP: begin
                seq_d.active = 1'b0;
            end
            default: begin
                if (seq_q.active) begin
                    iss_valid = 1'b1;
                    seq_d.idx = seq_q.idx + 1'b1;
                    if (seq_q.idx == seq_q.last) begin
                        seq_d.active = 1'b0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    sdr_col_gen #(.COL_W(COL_W)) u_col_gen (
        .start_col  (gen_start),
        .idx        (gen_idx),
        .wrap_mask  (gen_wrap),
        .interleave (gen_il),
        .col        (iss_col)
    );

endmodule

// File: rtl/sdr_page_mem.sv
module sdr_page_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W/8-1:0] wr_lane,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        for (int b = 0; b < LANES; b++) begin
            if (wr_lane[b]) begin
                mem_d[wr_addr][b*8 +: 8] = wr_data[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/sdr_read_pipe.sv
module sdr_read_pipe
    import sdr_dp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [DATA_W-1:0] iss_data,
    input  logic              cl3,
    input  logic [LANES-1:0]  dqm,
    output logic [DATA_W-1:0] rd_data,
    output logic [LANES-1:0]  rd_oe
);

    typedef struct packed {
        logic [MAX_CL-1:0]                  v;
        logic [MAX_CL-1:0][DATA_W-1:0]      d;
        logic [RD_MASK_LAT-1:0][LANES-1:0]  m;
        logic [DATA_W-1:0]                  od;
        logic [LANES-1:0]                   oe;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic              sel_v;
    logic [DATA_W-1:0] sel_d;

    always_comb begin
        pipe_d      = pipe_q;
        pipe_d.v[0] = iss_valid;
        pipe_d.d[0] = iss_data;
        for (int i = 1; i < MAX_CL; i++) begin
            pipe_d.v[i] = pipe_q.v[i-1];
            pipe_d.d[i] = pipe_q.d[i-1];
        end
        pipe_d.m[0] = dqm;
        for (int i = 1; i < RD_MASK_LAT; i++) begin
            pipe_d.m[i] = pipe_q.m[i-1];
        end

        // the output register adds the last clock of latency
        sel_v = cl3 ? pipe_q.v[MAX_CL-1] : pipe_q.v[MIN_CL-1];
        sel_d = cl3 ? pipe_q.d[MAX_CL-1] : pipe_q.d[MIN_CL-1];

        for (int b = 0; b < LANES; b++) begin
            pipe_d.oe[b]        = sel_v & ~pipe_q.m[RD_MASK_LAT-1][b];
            pipe_d.od[b*8 +: 8] = pipe_d.oe[b] ? sel_d[b*8 +: 8] : 8'h00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign rd_data = pipe_q.od;
    assign rd_oe   = pipe_q.oe;

endmodule

// File: rtl/sdr_burst_datapath.sv
module sdr_burst_datapath
    import sdr_dp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COL_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cmd,
    input  logic [COL_W-1:0]    col,
    input  logic [DATA_W/8-1:0] dqm,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                cfg_cl3,
    input  logic [1:0]          cfg_blen,
    input  logic                cfg_interleave,
    input  logic                cfg_single_wr,
    output logic [DATA_W-1:0]   rd_data,
    output logic [DATA_W/8-1:0] rd_oe
);

    localparam int LANES = DATA_W / 8;

    sdr_cmd_e          cmd_e;
    logic              iss_valid;
    logic              iss_write;
    logic [COL_W-1:0]  iss_col;
    logic [DATA_W-1:0] page_word;
    logic [LANES-1:0]  wr_lane;

    assign cmd_e = sdr_cmd_e'(cmd);

    sdr_burst_seq #(.COL_W(COL_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd_e),
        .col        (col),
        .blen_code  (cfg_blen),
        .interleave (cfg_interleave),
        .single_wr  (cfg_single_wr),
        .iss_valid  (iss_valid),
        .iss_write  (iss_write),
        .iss_col    (iss_col)
    );

    // write mask acts on the same clock as the write word
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign wr_lane[b] = iss_valid & iss_write & ~dqm[b];
    end

    sdr_page_mem #(.DATA_W(DATA_W), .ADDR_W(COL_W)) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lane (wr_lane),
        .wr_addr (iss_col),
        .wr_data (wdata),
        .rd_addr (iss_col),
        .rd_data (page_word)
    );

    sdr_read_pipe #(.DATA_W(DATA_W), .LANES(LANES)) u_rpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_valid (iss_valid & ~iss_write),
        .iss_data  (page_word),
        .cl3       (cfg_cl3),
        .dqm       (dqm),
        .rd_data   (rd_data),
        .rd_oe     (rd_oe)
    );

endmodule

// File: rtl/sdr_dp_checker.sv
module sdr_dp_checker
    import sdr_dp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COL_W  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          cmd,
    input logic [COL_W-1:0]    col,
    input logic [DATA_W/8-1:0] dqm,
    input logic                cfg_cl3,
    input logic                cfg_single_wr,
    input logic [DATA_W-1:0]   rd_data,
    input logic [DATA_W/8-1:0] rd_oe,
    input logic                iss_valid,
    input logic                iss_write,
    input logic [COL_W-1:0]    iss_col
);

    localparam int LANES = DATA_W / 8;

    AST_RD_FIRST_CL2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_READ && !cfg_cl3 && dqm == '0) |-> ##3 (rd_oe == '1)) else $error("read latency 2"); // R1
    AST_RD_FIRST_CL3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_READ && cfg_cl3 && dqm == '0) |-> ##4 (rd_oe == '1)) else $error("read latency 3"); // R1
    AST_READ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_READ) |-> (iss_valid && !iss_write && iss_col == col)) else $error("read restart"); // R6
    AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WRITE) |-> (iss_valid && iss_write && iss_col == col)) else $error("write restart"); // R5
    AST_STOP_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STOP) |-> !iss_valid) else $error("stop still issues"); // R7
    AST_STOP_DRAIN_CL2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STOP && !cfg_cl3) |-> ##3 (rd_oe == '0)) else $error("stop drain 2"); // R8
    AST_STOP_DRAIN_CL3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STOP && cfg_cl3) |-> ##4 (rd_oe == '0)) else $error("stop drain 3"); // R8
    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_single_wr && cmd == CMD_NOP) |-> !(iss_valid && iss_write)) else $error("extra write word"); // R9

    for (genvar b = 0; b < LANES; b++) begin : g_lane_chk
        AST_RD_MASK_LANE: assert property (@(posedge clk) disable iff (!rst_n)
            dqm[b] |-> ##3 !rd_oe[b]) else $error("read mask lane"); // R4
        AST_OFF_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_oe[b] |-> (rd_data[b*8 +: 8] == 8'h00)) else $error("disabled lane not zero"); // R10
    end

endmodule

bind sdr_burst_datapath sdr_dp_checker #(.DATA_W(DATA_W), .COL_W(COL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd           (cmd),
    .col           (col),
    .dqm           (dqm),
    .cfg_cl3       (cfg_cl3),
    .cfg_single_wr (cfg_single_wr),
    .rd_data       (rd_data),
    .rd_oe         (rd_oe),
    .iss_valid     (iss_valid),
    .iss_write     (iss_write),
    .iss_col       (iss_col)
);

// File: tb/tb_sdr_burst_datapath.sv
module tb_sdr_burst_datapath;

    localparam int DATA_W = 16;
    localparam int COL_W  = 4;
    localparam int DEPTH  = 16;
    localparam logic [1:0] NOP = 2'd0, RD = 2'd1, WR = 2'd2, BST = 2'd3;

    // {cl3, blen code, interleave, start column}
    localparam logic [7:0] VEC [8] = '{
        {1'b0, 2'd2, 1'b0, 4'd5},
        {1'b1, 2'd2, 1'b1, 4'd6},
        {1'b0, 2'd3, 1'b1, 4'd2},
        {1'b1, 2'd3, 1'b0, 4'd13},
        {1'b0, 2'd0, 1'b0, 4'd9},
        {1'b1, 2'd1, 1'b0, 4'd3},
        {1'b0, 2'd1, 1'b1, 4'd10},
        {1'b1, 2'd0, 1'b1, 4'd15}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cmd = NOP;
    logic [COL_W-1:0]  col = '0;
    logic [1:0]        dqm = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              cfg_cl3 = 1'b0;
    logic [1:0]        cfg_blen = 2'd0;
    logic              cfg_interleave = 1'b0;
    logic              cfg_single_wr = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic [1:0]        rd_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [DATA_W-1:0] model [DEPTH];

    always #2 clk = ~clk;

    sdr_burst_datapath #(.DATA_W(DATA_W), .COL_W(COL_W)) dut (
        .clk (clk), .rst_n (rst_n), .cmd (cmd), .col (col), .dqm (dqm), .wdata (wdata),
        .cfg_cl3 (cfg_cl3), .cfg_blen (cfg_blen), .cfg_interleave (cfg_interleave),
        .cfg_single_wr (cfg_single_wr), .rd_data (rd_data), .rd_oe (rd_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_col(input int s, input int i, input int len, input bit il);
        int base = s - (s % len);
        int off  = s % len;
        return il ? base + (off ^ i) : base + ((off + i) % len);
    endfunction

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            cmd = NOP; dqm = '0;
        end
    endtask

    // read a full burst and compare every word with the model
    task automatic read_burst(input int s, input string req);
        int lat = cfg_cl3 ? 3 : 2;
        int len = 1 << cfg_blen;
        @(negedge clk);
        cmd = RD; col = COL_W'(s); dqm = '0;
        for (int k = 1; k <= lat + len + 1; k++) begin
            logic [DATA_W-1:0] e;
            @(negedge clk);
            cmd = NOP;
            if (k <= lat + len) begin
                if (k >= lat + 1) begin
                    e = model[exp_col(s, k - lat - 1, len, cfg_interleave)];
                    chk(rd_oe == 2'b11 && rd_data == e, req, {14'd0, rd_oe, rd_data}, {14'd0, 2'b11, e});
                end
            end else begin
                chk(rd_oe == 2'b00 && rd_data == '0, {req, " end R2"}, {14'd0, rd_oe, rd_data}, 32'd0);
            end
        end
    endtask

    // burst write with a mask on the first word; model follows R5
    task automatic write_burst(input int s, input logic [15:0] base, input logic [1:0] m0);
        int len = 1 << cfg_blen;
        for (int i = 0; i < len; i++) begin
            int c;
            @(negedge clk);
            cmd = (i == 0) ? WR : NOP; col = COL_W'(s);
            wdata = base + 16'(i); dqm = (i == 0) ? m0 : 2'b00;
            c = exp_col(s, i, len, cfg_interleave);
            for (int b = 0; b < 2; b++) begin
                if (!dqm[b]) model[c][b*8 +: 8] = wdata[b*8 +: 8];
            end
        end
        idle(1);
    endtask

    // read burst with one word's lanes masked through dqm (R4)
    task automatic read_masked(input int s, input int mword, input logic [1:0] mval);
        int lat = cfg_cl3 ? 3 : 2;
        int len = 1 << cfg_blen;
        @(negedge clk);
        cmd = RD; col = COL_W'(s); dqm = '0;
        for (int k = 1; k <= lat + len + 1; k++) begin
            logic [DATA_W-1:0] e;
            logic [1:0] eo;
            @(negedge clk);
            if (k >= lat + 1 && k <= lat + len) begin
                eo = (k - lat - 1 == mword) ? ~mval : 2'b11;
                e  = model[exp_col(s, k - lat - 1, len, cfg_interleave)];
                e  = {eo[1] ? e[15:8] : 8'h00, eo[0] ? e[7:0] : 8'h00};
                chk(rd_oe == eo && rd_data == e, "R4 read mask", {14'd0, rd_oe, rd_data}, {14'd0, eo, e});
            end
            cmd = NOP;
            dqm = (k == lat + mword - 2) ? mval : 2'b00;
        end
        idle(1);
    endtask

    initial begin
        #(4 * 50000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all requirements actual=hang expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        chk(rd_oe == 2'b00 && rd_data == '0, "R10 in reset", {14'd0, rd_oe, rd_data}, 32'd0);
        rst_n = 1'b1;
        idle(2);
        chk(rd_oe == 2'b00 && rd_data == '0, "R10 after reset", {14'd0, rd_oe, rd_data}, 32'd0);
        cfg_blen = 2'd0;
        read_burst(5, "R10 page cleared");

        // fill the page with two sequential 8-word bursts
        cfg_blen = 2'd3; cfg_interleave = 1'b0;
        write_burst(0, 16'hA0B0, 2'b00);
        write_burst(8, 16'h5C30, 2'b00);

        // vector table: latency, length and order (R1 R2 R3)
        for (int v = 0; v < 8; v++) begin
            cfg_cl3 = VEC[v][7]; cfg_blen = VEC[v][6:5]; cfg_interleave = VEC[v][4];
            idle(1);
            read_burst(int'(VEC[v][3:0]), "R1,R2,R3 vector");
        end

        // R4: read mask, both latencies
        cfg_interleave = 1'b0; cfg_blen = 2'd2;
        cfg_cl3 = 1'b1; idle(1); read_masked(0, 1, 2'b01);
        cfg_cl3 = 1'b0; idle(1); read_masked(4, 2, 2'b10);

        // R5: write mask on the first word keeps the upper byte
        cfg_blen = 2'd1;
        write_burst(4, 16'h7E00, 2'b10);
        read_burst(4, "R5 write mask");

        // R6: read cut short by a read on the next clock
        cfg_blen = 2'd2; cfg_cl3 = 1'b0;
        @(negedge clk); cmd = RD; col = 4'd0;
        @(negedge clk); cmd = RD; col = 4'd8;
        for (int k = 2; k <= 8; k++) begin
            logic [DATA_W-1:0] e;
            @(negedge clk);
            cmd = NOP;
            if (k == 3) chk(rd_oe == 2'b11 && rd_data == model[0], "R6 first read word", {14'd0, rd_oe, rd_data}, {16'h3, model[0]});
            else if (k >= 4 && k <= 7) begin
                e = model[8 + k - 4];
                chk(rd_oe == 2'b11 && rd_data == e, "R6 restarted read", {14'd0, rd_oe, rd_data}, {16'h3, e});
            end else if (k == 8) chk(rd_oe == 2'b00, "R6 read end", {30'd0, rd_oe}, 32'd0);
        end
        idle(2);

        // R6: write cut short by a write
        @(negedge clk); cmd = WR; col = 4'd2; wdata = 16'h1111; model[2] = 16'h1111;
        @(negedge clk); cmd = WR; col = 4'd12; wdata = 16'h2222; model[12] = 16'h2222;
        for (int i = 1; i < 4; i++) begin
            @(negedge clk); cmd = NOP; wdata = 16'h2222 + 16'(i); model[12 + i] = wdata;
        end
        idle(1);
        read_burst(0, "R6 write abandoned");
        read_burst(12, "R6 write restarted");

        // R7: burst stop during a write
        @(negedge clk); cmd = WR; col = 4'd8; wdata = 16'h3330; model[8] = 16'h3330;
        @(negedge clk); cmd = NOP; wdata = 16'h3331; model[9] = 16'h3331;
        @(negedge clk); cmd = BST; wdata = 16'h3332;
        @(negedge clk); cmd = NOP; wdata = 16'h3333;
        idle(1);
        read_burst(8, "R7 write stop");

        // R8: burst stop during a read, latency 3, length 8
        cfg_cl3 = 1'b1; cfg_blen = 2'd3;
        idle(1);
        @(negedge clk); cmd = RD; col = 4'd0;
        @(negedge clk); cmd = NOP;
        @(negedge clk); cmd = BST;
        for (int k = 3; k <= 11; k++) begin
            @(negedge clk);
            cmd = NOP;
            if (k == 4 || k == 5)
                chk(rd_oe == 2'b11 && rd_data == model[k - 4], "R8 words before stop", {14'd0, rd_oe, rd_data}, {16'h3, model[k - 4]});
            else if (k >= 6)
                chk(rd_oe == 2'b00 && rd_data == '0, "R8 quiet after stop", {14'd0, rd_oe, rd_data}, 32'd0);
        end

        // R9: single-word write mode, reads keep the burst length
        cfg_cl3 = 1'b0; cfg_blen = 2'd2; cfg_single_wr = 1'b1;
        idle(1);
        @(negedge clk); cmd = WR; col = 4'd4; wdata = 16'h4440; model[4] = 16'h4440;
        for (int i = 1; i < 4; i++) begin
            @(negedge clk); cmd = NOP; wdata = 16'h4440 + 16'(i);
        end
        idle(1);
        read_burst(4, "R9 single write");
        cfg_single_wr = 1'b0;
        idle(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule